// File: doc/BRIEF.md
# Programmable Cosmic Coincidence Selector

This block turns one sample of per-chip hit flags from a two-layer barrel pixel detector into a single registered cosmic-ray trigger bit. The flags are split by layer (inner and outer) and, inside each layer, by module index into a top half and a bottom half. Each of the four regions is reduced to two bits: "any chip hit" and "at least two chips hit". The second bit comes from a saturating two-count, not a full population count.

A 3-bit rule register picks which geometric coincidence of these region summaries drives the trigger. Six codes are defined. The two spare codes hold the trigger low. The register is written through a simple write strobe and takes effect from the next sample. Samples are marked by a valid strobe, and the trigger for a sample appears on the cycle after it.

Top module: `cosmic_coinc_sel`

## Requirements
- R1: With rule code 0, the trigger is high when at least one top outer chip and at least one bottom outer chip are flagged.
- R2: With rule code 1, the trigger is high when at least one inner chip and at least one outer chip are flagged.
- R3: With rule code 2, the trigger is high when at least two inner chips and at least two outer chips are flagged. The two chips may lie in the same half or in different halves.
- R4: With rule code 3, the trigger is high only when top outer, top inner, bottom outer and bottom inner are each hit.
- R5: With rule code 4, the trigger is high when top outer, bottom outer and any inner chip are all hit.
- R6: With rule code 5, the trigger is the OR of every flag.
- R7: Rule codes 6 and 7 hold the trigger low for any flag pattern.
- R8: The trigger for a sample with `sample_valid` high appears on the next rising edge. The trigger is low after any edge where `sample_valid` was low.
- R9: The rule register resets to 0 and changes only on a cycle with `rule_we` high. A sample taken in the same cycle as a write uses the old rule; the new rule applies from the next sample.
- R10: Flag layout, with 10 chips per module and chip c of module m at bit m*10+c of its layer's slice. Inner bits 0..399 hold 40 modules: modules 0..19 (bits 0..199) are top and the rest are bottom. Outer bits 400..1199 hold 80 modules: bits 400..799 are top and bits 800..1199 are bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rule_we | input | 1 | Write strobe for the rule register |
| rule_wdata | input | 3 | New rule code |
| sample_valid | input | 1 | Marks a hit-flag sample |
| hit_flags | input | 1200 | Per-chip hit flags, layout per R10 |
| trig_o | output | 1 | Registered cosmic trigger |

## Verification
On every cycle the assertions check that the spare codes never fire, that the trigger is low after an idle cycle, and that an empty sample never fires. They also check that the rule register holds without a write and that rule 0 stays silent without a top outer hit. Only the bench scenarios show that each of the six rules gives the right answer over a table of flag patterns. The bench also covers the region boundaries at the top/bottom split and the ordering of a rule write against a sample in the same cycle.

// File: rtl/cosmic_sel_pkg.sv
package cosmic_sel_pkg;
    localparam int RULE_W = 3;

    localparam logic [RULE_W-1:0] RULE_OUTER_PAIR  = 3'd0;
    localparam logic [RULE_W-1:0] RULE_BOTH_LAYERS = 3'd1;
    localparam logic [RULE_W-1:0] RULE_TWO_EACH    = 3'd2;
    localparam logic [RULE_W-1:0] RULE_FOUR_QUAD   = 3'd3;
    localparam logic [RULE_W-1:0] RULE_PAIR_INNER  = 3'd4;
    localparam logic [RULE_W-1:0] RULE_GLOBAL      = 3'd5;

    typedef struct packed {
        logic any;
        logic multi;
    } region_sum_t;

    typedef struct packed {
        logic [RULE_W-1:0] rule;
        logic              trig;
    } sel_state_t;
endpackage

// File: rtl/cosmic_region_reduce.sv
module cosmic_region_reduce
    import cosmic_sel_pkg::*;
#(
    parameter int W = 200
) (
    input  logic [W-1:0] flags,
    output region_sum_t  sum
);
    logic any_acc;
    logic multi_acc;

    // Saturating two-count: multi latches once a second hit follows the first
    always_comb begin
        any_acc   = 1'b0;
        multi_acc = 1'b0;
        for (int i = 0; i < W; i++) begin
            multi_acc = multi_acc | (any_acc & flags[i]);
            any_acc   = any_acc | flags[i];
        end
    end

    assign sum.any   = any_acc;
    assign sum.multi = multi_acc;
endmodule

// File: rtl/cosmic_rule_mux.sv
module cosmic_rule_mux
    import cosmic_sel_pkg::*;
(
    input  region_sum_t       in_top,
    input  region_sum_t       in_bot,
    input  region_sum_t       out_top,
    input  region_sum_t       out_bot,
    input  logic [RULE_W-1:0] rule,
    output logic              fire
);
    logic inner_any, outer_any, inner_two, outer_two;

    always_comb begin
        inner_any = in_top.any | in_bot.any;
        outer_any = out_top.any | out_bot.any;
        inner_two = in_top.multi | in_bot.multi | (in_top.any & in_bot.any);
        outer_two = out_top.multi | out_bot.multi | (out_top.any & out_bot.any);
        case (rule)
            RULE_OUTER_PAIR:  fire = out_top.any & out_bot.any;
            RULE_BOTH_LAYERS: fire = inner_any & outer_any;
            RULE_TWO_EACH:    fire = inner_two & outer_two;
            RULE_FOUR_QUAD:   fire = out_top.any & in_top.any & out_bot.any & in_bot.any;
            RULE_PAIR_INNER:  fire = out_top.any & out_bot.any & inner_any;
            RULE_GLOBAL:      fire = inner_any | outer_any;
            default:          fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/cosmic_coinc_sel.sv
module cosmic_coinc_sel
    import cosmic_sel_pkg::*;
#(
    parameter int CHIPS_PER_MOD = 10,
    parameter int INNER_MODS    = 40,
    parameter int OUTER_MODS    = 80,
    localparam int INNER_W      = INNER_MODS * CHIPS_PER_MOD,
    localparam int OUTER_W      = OUTER_MODS * CHIPS_PER_MOD,
    localparam int TOTAL_W      = INNER_W + OUTER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rule_we,
    input  logic [RULE_W-1:0]  rule_wdata,
    input  logic               sample_valid,
    input  logic [TOTAL_W-1:0] hit_flags,
    output logic               trig_o
);
    localparam int IN_TOP_W  = (INNER_MODS / 2) * CHIPS_PER_MOD;
    localparam int IN_BOT_W  = INNER_W - IN_TOP_W;
    localparam int OUT_TOP_W = (OUTER_MODS / 2) * CHIPS_PER_MOD;
    localparam int OUT_BOT_W = OUTER_W - OUT_TOP_W;

    region_sum_t in_top, in_bot, out_top, out_bot;
    logic        fire;
    sel_state_t  st_d, st_q;

    cosmic_region_reduce #(.W(IN_TOP_W)) u_in_top (
        .flags(hit_flags[IN_TOP_W-1:0]), .sum(in_top));
    cosmic_region_reduce #(.W(IN_BOT_W)) u_in_bot (
        .flags(hit_flags[INNER_W-1:IN_TOP_W]), .sum(in_bot));
    cosmic_region_reduce #(.W(OUT_TOP_W)) u_out_top (
        .flags(hit_flags[INNER_W+OUT_TOP_W-1:INNER_W]), .sum(out_top));
    cosmic_region_reduce #(.W(OUT_BOT_W)) u_out_bot (
        .flags(hit_flags[TOTAL_W-1:INNER_W+OUT_TOP_W]), .sum(out_bot));

    cosmic_rule_mux u_mux (
        .in_top (in_top),
        .in_bot (in_bot),
        .out_top(out_top),
        .out_bot(out_bot),
        .rule   (st_q.rule),
        .fire   (fire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trig = sample_valid & fire;
        if (rule_we) st_d.rule = rule_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o = st_q.trig;

    AST_SPARE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && st_q.rule > RULE_GLOBAL) |=> !trig_o); // R7
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> !trig_o); // R8
    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && hit_flags == '0) |=> !trig_o); // R6
    AST_RULE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rule_we |=> $stable(st_q.rule)); // R9
    AST_PAIR_NEEDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && st_q.rule == RULE_OUTER_PAIR &&
         hit_flags[INNER_W+OUT_TOP_W-1:INNER_W] == '0) |=> !trig_o); // R1
endmodule

// File: tb/cosmic_coinc_sel_test.sv
module cosmic_coinc_sel_test;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rule_we = 1'b0;
    logic [2:0]    rule_wdata = '0;
    logic          sample_valid = 1'b0;
    logic [1199:0] hit_flags = '0;
    logic          trig_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cosmic_coinc_sel uut (
        .clk(clk), .rst_n(rst_n), .rule_we(rule_we), .rule_wdata(rule_wdata),
        .sample_valid(sample_valid), .hit_flags(hit_flags), .trig_o(trig_o));

    always #5 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: trig_o=%b expected %b", req, act, exp);
        end
    endtask

    function automatic int count_range(input logic [1199:0] f, input int lo, input int hi);
        int n = 0;
        for (int i = lo; i <= hi; i++) n += int'(f[i]);
        return n;
    endfunction

    // Expected value derived from R1..R7 and the R10 layout
    function automatic logic model(input logic [2:0] r, input logic [1199:0] f);
        int it = count_range(f, 0, 199);
        int ib = count_range(f, 200, 399);
        int ot = count_range(f, 400, 799);
        int ob = count_range(f, 800, 1199);
        case (r)
            3'd0: return (ot > 0) && (ob > 0);
            3'd1: return (it + ib > 0) && (ot + ob > 0);
            3'd2: return (it + ib >= 2) && (ot + ob >= 2);
            3'd3: return (ot > 0) && (it > 0) && (ob > 0) && (ib > 0);
            3'd4: return (ot > 0) && (ob > 0) && (it + ib > 0);
            3'd5: return (f != '0);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [1199:0] pattern(input int p);
        logic [1199:0] f = '0;
        case (p)
            1: begin f[400] = 1; f[1199] = 1; end
            2: begin f[0] = 1; f[799] = 1; end
            3: begin f[5] = 1; f[6] = 1; f[800] = 1; f[801] = 1; end
            4: begin f[10] = 1; f[399] = 1; f[500] = 1; f[900] = 1; end
            5: begin f[199] = 1; f[200] = 1; f[799] = 1; f[800] = 1; end
            6: begin f[1000] = 1; end
            7: begin f[50] = 1; f[400] = 1; f[401] = 1; end
            default: ;
        endcase
        return f;
    endfunction

    task automatic write_rule(input logic [2:0] r);
        @(negedge clk);
        rule_we = 1'b1; rule_wdata = r;
        @(negedge clk);
        rule_we = 1'b0;
    endtask

    task automatic sample_and_check(input logic [1199:0] f, input logic exp, input string req);
        @(negedge clk);
        hit_flags = f; sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        check(trig_o, exp, req);
    endtask

    task automatic test_reset;
        check(trig_o, 1'b0, "R8 reset");
        // rule defaults to 0: outer top+bottom fires, inner+outer top does not
        sample_and_check(pattern(1), 1'b1, "R9 reset rule");
        sample_and_check(pattern(2), 1'b0, "R9 reset rule");
    endtask

    task automatic test_rule_table;
        for (int r = 0; r < 8; r++) begin
            write_rule(3'(r));
            for (int p = 0; p < 8; p++) begin
                string tag;
                case (r)
                    0: tag = "R1"; 1: tag = "R2"; 2: tag = "R3"; 3: tag = "R4";
                    4: tag = "R5"; 5: tag = "R6"; default: tag = "R7";
                endcase
                sample_and_check(pattern(p), model(3'(r), pattern(p)), tag);
            end
        end
    endtask

    task automatic test_boundaries;
        logic [1199:0] f;
        write_rule(3'd3);
        f = '0; f[199] = 1; f[200] = 1; f[799] = 1; f[800] = 1;
        sample_and_check(f, 1'b1, "R10 split edges");
        f = '0; f[198] = 1; f[199] = 1; f[799] = 1; f[800] = 1;
        sample_and_check(f, 1'b0, "R10 inner bottom empty");
        write_rule(3'd2);
        f = '0; f[199] = 1; f[200] = 1; f[799] = 1; f[800] = 1;
        sample_and_check(f, 1'b1, "R3 split halves");
        f = '0; f[0] = 1; f[400] = 1; f[1199] = 1;
        sample_and_check(f, 1'b0, "R3 one inner");
    endtask

    task automatic test_timing;
        write_rule(3'd5);
        @(negedge clk);
        hit_flags = pattern(6); sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        check(trig_o, 1'b1, "R8 one cycle");
        @(negedge clk);
        check(trig_o, 1'b0, "R8 idle low");
        // write and sample together: old rule 5 applies, then new rule 6
        @(negedge clk);
        rule_we = 1'b1; rule_wdata = 3'd6; sample_valid = 1'b1; hit_flags = pattern(6);
        @(negedge clk);
        rule_we = 1'b0;
        check(trig_o, 1'b1, "R9 old rule same cycle");
        @(negedge clk);
        sample_valid = 1'b0;
        check(trig_o, 1'b0, "R9 new rule next sample");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_rule_table();
        test_boundaries();
        test_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule